// File: doc/BRIEF.md
# Software Trace Stimulus Unit

Software writes values to one of 32 stimulus port registers. The unit turns each accepted write into a short trace packet on a byte-wide output stream that uses a valid/ready handshake. A packet is a header byte followed by one, two or four payload bytes. The header names the port and the payload size. The active trace source ID is driven on its own output so that a downstream formatter can tag the stream.

Configuration lives behind a key-protected lock. A control register holds the global enable, the synchronisation enable and the 7-bit source ID. A 32-bit mask enables individual ports, and a 4-bit mask unmasks ports in groups of eight. Accepted writes queue in a small FIFO. Software can poll any stimulus port address to learn whether a new write would be taken. With synchronisation on, a fixed six-byte marker is placed into the stream about every 256 output bytes, always at a packet boundary.

Top module: `trace_stim_unit`

## Requirements
- R1: After reset the unit is locked, and the lock register reads 0 in bit 0. Writes to the port-enable, group-mask and control registers change nothing until 0xC5ACCE55 is written to the lock register (word address 0x23), after which the lock register reads 1.
- R2: Writing any other value to the lock register locks the unit again, and later configuration writes are ignored.
- R3: Control register (word address 0x22): bit 0 is the global enable, bit 2 is the sync enable, and bits 22:16 hold the source ID. All other bits read 0. `trc_id_o` equals the ID field.
- R4: A stimulus write is dropped while the global enable is 0 or the source ID is 0.
- R5: Bit n of the port-enable register (word address 0x20) must be 1 for a write to port n (word address n, 0..31) to be accepted.
- R6: Bit g of the group-mask register (word address 0x21, bits 3:0) must be 1 for a write to ports 8g..8g+7 to be accepted.
- R7: A packet is a header byte {port[4:0], 1'b0, size code[1:0]}, followed by the payload, least significant byte first. The write size `bus_size_i` is 0 for a byte, 1 for a halfword and 2 or 3 for a word. These give size codes 01, 10 and 11, with 1, 2 and 4 payload bytes.
- R8: A read of any stimulus port address returns 1 in bit 0 when the queue can take a write and 0 when it is full. A write made while the queue is full is dropped. With the output stalled, five writes are accepted: four in the queue and one in the packet builder.
- R9: With global enable and sync enable both set, a six-byte marker (five 0x00 bytes, then 0x80) starts at the first packet boundary at which at least 256 bytes have been sent since sync was enabled or since the previous marker began. No marker is sent before that point.
- R10: While `trc_valid_o` is high and `trc_ready_i` is low, `trc_valid_o` stays high and `trc_data_o` does not change.
- R11: Accepted writes come out in the order they were accepted. None is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_size_i | input | 2 | Write size: 0 byte, 1 halfword, 2 or 3 word |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for the address on `bus_addr_i` (combinational) |
| trc_data_o | output | 8 | Trace stream byte |
| trc_valid_o | output | 1 | Trace byte valid |
| trc_ready_i | input | 1 | Downstream accepts the byte |
| trc_id_o | output | 7 | Current trace source ID |

## Verification
The hardest case to reach is a marker that becomes due while a packet is being sent or while the output is stalled. The marker must then wait for the boundary, and it must not slip in between a header and its payload. To get there, the bench sends a long run of writes with random sizes and random ports, with sync on and a randomly toggling ready. This pushes the byte count past 256 several times at arbitrary points inside packets. The bench also fills the queue with the output held stalled, so that dropped and accepted writes follow each other directly, and it checks whether each write was accepted through the port-status read made in the same cycle.

// File: rtl/trace_stim_pkg.sv
package trace_stim_pkg;
  localparam int unsigned PORT_W   = 5;
  localparam int unsigned N_PORTS  = 1 << PORT_W;
  localparam int unsigned N_GROUPS = N_PORTS / 8;
  localparam int unsigned ADDR_W   = PORT_W + 1;
  localparam int unsigned ID_W     = 7;

  localparam logic [ADDR_W-1:0] ADDR_PEN  = ADDR_W'(N_PORTS + 0);
  localparam logic [ADDR_W-1:0] ADDR_GRP  = ADDR_W'(N_PORTS + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(N_PORTS + 2);
  localparam logic [ADDR_W-1:0] ADDR_LOCK = ADDR_W'(N_PORTS + 3);

  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_WORD = 2'b11
  } size_code_e;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    size_code_e        size;
    logic [31:0]       data;
  } stim_entry_t;

  function automatic logic [2:0] payload_len(size_code_e c);
    case (c)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/tsu_regs.sv
module tsu_regs
  import trace_stim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic              fifo_full_i,
  output logic [31:0]       rdata_o,
  output logic              push_o,
  output stim_entry_t       entry_o,
  output logic              unlocked_o,
  output logic [N_PORTS-1:0] pen_o,
  output logic              en_o,
  output logic              sync_o,
  output logic [ID_W-1:0]   id_o
);
  logic                unlocked_q;
  logic [N_PORTS-1:0]  pen_q;
  logic [N_GROUPS-1:0] grp_q;
  logic                en_q, sync_q;
  logic [ID_W-1:0]     id_q;

  logic              is_stim;
  logic [PORT_W-1:0] port;
  logic              port_open;

  assign is_stim   = ~addr_i[ADDR_W-1];
  assign port      = addr_i[PORT_W-1:0];
  assign port_open = pen_q[port] & grp_q[port[PORT_W-1:3]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      pen_q      <= '0;
      grp_q      <= '0;
      en_q       <= 1'b0;
      sync_q     <= 1'b0;
      id_q       <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_LOCK: unlocked_q <= (wdata_i == UNLOCK_KEY);
        ADDR_PEN:  if (unlocked_q) pen_q <= wdata_i[N_PORTS-1:0];
        ADDR_GRP:  if (unlocked_q) grp_q <= wdata_i[N_GROUPS-1:0];
        ADDR_CTRL: if (unlocked_q) begin
          en_q   <= wdata_i[0];
          sync_q <= wdata_i[2];
          id_q   <= wdata_i[16 +: ID_W];
        end
        default: ;
      endcase
    end
  end

  assign push_o = we_i & is_stim & en_q & (id_q != '0) & port_open & ~fifo_full_i;

  always_comb begin
    entry_o.port = port;
    entry_o.data = wdata_i;
    case (size_i)
      2'd0:    entry_o.size = SZ_BYTE;
      2'd1:    entry_o.size = SZ_HALF;
      default: entry_o.size = SZ_WORD;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (is_stim) begin
      rdata_o[0] = ~fifo_full_i;
    end else begin
      case (addr_i)
        ADDR_PEN:  rdata_o[N_PORTS-1:0] = pen_q;
        ADDR_GRP:  rdata_o[N_GROUPS-1:0] = grp_q;
        ADDR_CTRL: begin
          rdata_o[0]          = en_q;
          rdata_o[2]          = sync_q;
          rdata_o[16 +: ID_W] = id_q;
        end
        ADDR_LOCK: rdata_o[0] = unlocked_q;
        default: ;
      endcase
    end
  end

  assign unlocked_o = unlocked_q;
  assign pen_o      = pen_q;
  assign en_o       = en_q;
  assign sync_o     = sync_q;
  assign id_o       = id_q;
endmodule

// File: rtl/tsu_fifo.sv
module tsu_fifo #(
  parameter int unsigned WIDTH = 39,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsu_serializer.sv
module tsu_serializer
  import trace_stim_pkg::*;
#(
  parameter int unsigned SYNC_PERIOD = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sync_en_i,
  input  logic        fifo_empty_i,
  input  stim_entry_t fifo_rdata_i,
  output logic        pop_o,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  data_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_PERIOD + 1);
  localparam logic [CNT_W-1:0] PERIOD = CNT_W'(SYNC_PERIOD);
  localparam logic [2:0] SYNC_LAST = 3'd5;

  logic        busy_q, is_sync_q;
  logic [2:0]  idx_q;
  stim_entry_t cur_q;
  logic [CNT_W-1:0] since_q;

  logic       sync_due, load_sync, xfer;
  logic [2:0] last_idx;

  assign sync_due  = sync_en_i & (since_q >= PERIOD);
  assign load_sync = ~busy_q & sync_due;
  assign pop_o     = ~busy_q & ~sync_due & ~fifo_empty_i;
  assign xfer      = busy_q & ready_i;
  assign last_idx  = is_sync_q ? SYNC_LAST : payload_len(cur_q.size);
  assign valid_o   = busy_q;

  always_comb begin
    if (is_sync_q) begin
      data_o = (idx_q == SYNC_LAST) ? 8'h80 : 8'h00;
    end else begin
      case (idx_q)
        3'd0:    data_o = {cur_q.port, 1'b0, cur_q.size};
        3'd1:    data_o = cur_q.data[7:0];
        3'd2:    data_o = cur_q.data[15:8];
        3'd3:    data_o = cur_q.data[23:16];
        default: data_o = cur_q.data[31:24];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      is_sync_q <= 1'b0;
      idx_q     <= '0;
      cur_q     <= '0;
    end else if (load_sync) begin
      busy_q    <= 1'b1;
      is_sync_q <= 1'b1;
      idx_q     <= '0;
    end else if (pop_o) begin
      busy_q    <= 1'b1;
      is_sync_q <= 1'b0;
      idx_q     <= '0;
      cur_q     <= fifo_rdata_i;
    end else if (xfer) begin
      if (idx_q == last_idx) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  // bytes sent since sync enable or since the last marker began, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            since_q <= '0;
    else if (!sync_en_i || load_sync)       since_q <= '0;
    else if (xfer && since_q != PERIOD)     since_q <= since_q + 1'b1;
  end
endmodule

// File: rtl/trace_stim_unit.sv
module trace_stim_unit
  import trace_stim_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_PERIOD = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_we_i,
  output logic [31:0]       bus_rdata_o,
  output logic [7:0]        trc_data_o,
  output logic              trc_valid_o,
  input  logic              trc_ready_i,
  output logic [ID_W-1:0]   trc_id_o
);
  localparam int unsigned ENTRY_W = $bits(stim_entry_t);

  logic               stim_push, fifo_pop, fifo_full, fifo_empty;
  stim_entry_t        push_entry, head_entry;
  logic               cfg_unlocked, cfg_en, cfg_sync;
  logic [N_PORTS-1:0] cfg_pen;

  tsu_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .size_i     (bus_size_i),
    .we_i       (bus_we_i),
    .fifo_full_i(fifo_full),
    .rdata_o    (bus_rdata_o),
    .push_o     (stim_push),
    .entry_o    (push_entry),
    .unlocked_o (cfg_unlocked),
    .pen_o      (cfg_pen),
    .en_o       (cfg_en),
    .sync_o     (cfg_sync),
    .id_o       (trc_id_o)
  );

  tsu_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (stim_push),
    .wdata_i(push_entry),
    .pop_i  (fifo_pop),
    .rdata_o(head_entry),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  tsu_serializer #(.SYNC_PERIOD(SYNC_PERIOD)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_en_i   (cfg_en & cfg_sync),
    .fifo_empty_i(fifo_empty),
    .fifo_rdata_i(head_entry),
    .pop_o       (fifo_pop),
    .ready_i     (trc_ready_i),
    .valid_o     (trc_valid_o),
    .data_o      (trc_data_o)
  );
endmodule

// File: rtl/trace_stim_checker.sv
module trace_stim_checker
  import trace_stim_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic               bus_we_i,
  input logic [7:0]         trc_data_o,
  input logic               trc_valid_o,
  input logic               trc_ready_i,
  input logic [ID_W-1:0]    trc_id_o,
  input logic               stim_push,
  input logic               fifo_pop,
  input logic               fifo_full,
  input logic               cfg_unlocked,
  input logic [N_PORTS-1:0] cfg_pen
);
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && !trc_ready_i |=> trc_valid_o && $stable(trc_data_o)); // R10

  AST_LOCKED_NO_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlocked && bus_we_i && bus_addr_i == ADDR_PEN |=> $stable(cfg_pen)); // R1

  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_LOCK && bus_wdata_i != UNLOCK_KEY |=> !cfg_unlocked); // R2

  AST_ID_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_id_o == '0 |-> !stim_push); // R4

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full && !fifo_pop |=> fifo_full); // R8
endmodule

bind trace_stim_unit trace_stim_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_we_i    (bus_we_i),
  .trc_data_o  (trc_data_o),
  .trc_valid_o (trc_valid_o),
  .trc_ready_i (trc_ready_i),
  .trc_id_o    (trc_id_o),
  .stim_push   (stim_push),
  .fifo_pop    (fifo_pop),
  .fifo_full   (fifo_full),
  .cfg_unlocked(cfg_unlocked),
  .cfg_pen     (cfg_pen)
);

// File: tb/trace_stim_unit_tb.sv
module trace_stim_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  tdata;
  logic        tvalid;
  logic        tready = 1'b0;
  logic [6:0]  tid;

  always #5 clk = ~clk;

  trace_stim_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_size_i(size), .bus_we_i(we), .bus_rdata_o(rdata),
    .trc_data_o(tdata), .trc_valid_o(tvalid), .trc_ready_i(tready), .trc_id_o(tid)
  );

  int n_chk = 0, n_fail = 0;
  logic [38:0] exp_q [$];
  // bench copy of configuration as written through the bus
  bit        m_en = 0;
  logic [6:0] m_id = '0;
  logic [31:0] m_pen = '0;
  logic [3:0]  m_grp = '0;
  int  rdy_mode = 0;
  bit  mon_on = 0;
  bit  sync_on = 0;
  int  since = 0, sync_pos = 0, n_sync = 0, pk_idx = 0, pk_len = 0;
  bit  in_pkt = 0;
  logic [38:0] cur;
  bit  prev_stall = 0;
  logic [7:0] prev_data;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(logic [1:0] s);
    return (s == 2'd0) ? 2'b01 : (s == 2'd1) ? 2'b10 : 2'b11;
  endfunction

  function automatic int len_of(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [1:0] s, output bit room);
    addr = a; wdata = d; size = s; we = 1'b1;
    #1;
    room = rdata[0];
    if (a < 6'd32) begin
      if (room && m_en && m_id != 0 && m_pen[a[4:0]] && m_grp[a[4:3]])
        exp_q.push_back({a[4:0], code_of(s), d});
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg(logic [5:0] a, logic [31:0] d);
    bit r;
    wr(a, d, 2'd2, r);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
    @(negedge clk);
  endtask

  task automatic drain();
    int quiet = 0;
    rdy_mode = 1;
    while (quiet < 20) begin
      @(negedge clk);
      #2;
      if (tvalid) quiet = 0; else quiet++;
    end
  endtask

  // output monitor and stream parser
  always @(negedge clk) begin
    if (mon_on) begin
      tready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
      #1;
      if (prev_stall)
        chk(tvalid && tdata == prev_data, "R10", "stalled byte changed", {tvalid, tdata}, {1'b1, prev_data});
      prev_stall = tvalid && !tready;
      prev_data  = tdata;
      if (tvalid && tready) begin
        if (sync_pos > 0) begin
          chk(tdata == ((sync_pos < 5) ? 8'h00 : 8'h80), "R9", "marker byte", tdata, (sync_pos < 5) ? 8'h00 : 8'h80);
          sync_pos = (sync_pos == 5) ? 0 : sync_pos + 1;
        end else if (in_pkt) begin
          chk(tdata == 8'(cur[31:0] >> (8 * pk_idx)), "R7", "payload byte", tdata, 8'(cur[31:0] >> (8 * pk_idx)));
          pk_idx++;
          if (pk_idx == pk_len) in_pkt = 0;
        end else if (sync_on && since >= 256) begin
          chk(tdata == 8'h00, "R9", "marker due at boundary", tdata, 0);
          sync_pos = 1; since = 0; n_sync++;
        end else if (exp_q.size() == 0) begin
          chk(0, "R5", "unexpected byte", tdata, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(tdata == {cur[38:34], 1'b0, cur[33:32]}, "R11", "header in order", tdata, {cur[38:34], 1'b0, cur[33:32]});
          pk_len = len_of(cur[33:32]); pk_idx = 0; in_pkt = 1;
        end
        if (sync_on) since++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit r;
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);

    // reset state, lock
    rd(6'h23, d); chk(d == 0, "R1", "lock after reset", d, 0);
    chk(!tvalid, "R1", "idle after reset", tvalid, 0);
    cfg(6'h20, 32'hFFFF);
    rd(6'h20, d); chk(d == 0, "R1", "enable write while locked", d, 0);
    cfg(6'h23, 32'hC5AC_CE55);
    rd(6'h23, d); chk(d == 1, "R1", "lock after key", d, 1);
    cfg(6'h20, 32'hFFFF_FFF7); m_pen = 32'hFFFF_FFF7;
    cfg(6'h21, 32'hD); m_grp = 4'hD;
    rd(6'h20, d); chk(d == 32'hFFFF_FFF7, "R1", "enable write unlocked", d, 32'hFFFF_FFF7);

    // control fields
    cfg(6'h22, 32'hFFFF_FFFF);
    rd(6'h22, d); chk(d == 32'h007F_0005, "R3", "control readback mask", d, 32'h007F_0005);
    chk(tid == 7'h7F, "R3", "id output", tid, 7'h7F);
    cfg(6'h22, 32'h0001_0001); m_en = 1; m_id = 1;
    rd(6'h22, d); chk(d == 32'h0001_0001, "R3", "control readback", d, 32'h0001_0001);
    chk(tid == 7'h01, "R3", "id output", tid, 1);

    // relock
    cfg(6'h23, 32'h1);
    cfg(6'h20, 32'h0);
    rd(6'h20, d); chk(d == 32'hFFFF_FFF7, "R2", "write after relock", d, 32'hFFFF_FFF7);
    rd(6'h23, d); chk(d == 0, "R2", "lock state", d, 0);
    cfg(6'h23, 32'hC5AC_CE55);

    // packet format, directed sizes
    rdy_mode = 1;
    wr(6'd0, 32'h0000_00A5, 2'd0, r);
    wr(6'd1, 32'h0000_1234, 2'd1, r);
    wr(6'd31, 32'hDEAD_BEEF, 2'd2, r);
    wr(6'd30, 32'h0102_0304, 2'd3, r);
    drain();
    chk(exp_q.size() == 0, "R7", "directed packets delivered", exp_q.size(), 0);

    // disabled port and masked group: no bytes may appear
    wr(6'd3, 32'h55, 2'd0, r);
    wr(6'd9, 32'h66, 2'd0, r);
    drain();
    chk(exp_q.size() == 0, "R5", "disabled port silent", exp_q.size(), 0);
    chk(exp_q.size() == 0, "R6", "masked group silent", exp_q.size(), 0);

    // zero id, then global enable off
    cfg(6'h22, 32'h0000_0001); m_id = 0;
    wr(6'd0, 32'h77, 2'd0, r);
    cfg(6'h22, 32'h0001_0000); m_id = 1; m_en = 0;
    wr(6'd0, 32'h88, 2'd0, r);
    drain();
    chk(exp_q.size() == 0 && !tvalid, "R4", "gated writes silent", exp_q.size(), 0);
    cfg(6'h22, 32'h0001_0001); m_en = 1;

    // fill with output stalled
    rdy_mode = 0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      wr(6'd0, 32'h10 + i, 2'd0, r);
      chk(r == (i < 5), "R8", "room flag during fill", r, i < 5);
    end
    rd(6'd4, d); chk(d[0] == 0, "R8", "full status on other port", d[0], 0);
    drain();
    rd(6'd0, d); chk(d[0] == 1, "R8", "room after drain", d[0], 1);
    chk(exp_q.size() == 0, "R11", "stalled packets delivered", exp_q.size(), 0);

    // random traffic with sync markers
    cfg(6'h22, 32'h0001_0005);
    sync_on = 1; since = 0;
    rdy_mode = 2;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 5 == 0) @(negedge clk);
      else wr(6'($urandom % 32), $urandom, 2'($urandom % 4), r);
    end
    drain();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0 && !in_pkt && sync_pos == 0, "R11", "random packets delivered", exp_q.size(), 0);
    chk(n_sync >= 2, "R9", "markers seen", n_sync, 2);

    summary();
    $finish;
  end
endmodule